// File: doc/BRIEF.md
# Effective Address and Bounds Unit

This unit sits in the issue stage of a small multiprocessor core. For each issued instruction it forms the word address that a memory-touching opcode needs and checks that address against the size of the attached memory. Direct loads and stores are relative to the program counter. Indirect accesses add a displacement to a base register. Push and pop work on the stack pointer. Load-address and load-immediate only produce a register result.

Any address that does not land inside the memory stops the issuing processor. The unit then raises a sticky fault flag and issues nothing more until reset. A valid address produces a one-cycle memory request with a write enable and store data. Where the opcode calls for it, the unit also produces a register write-back value or a new stack pointer.

All outputs are registered, so they appear on the cycle after the issue.

Top module: `addr_guard_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every output is 0: `memReq`, `memWe`, `regWe`, `spWe`, `fault`, and every data and address bus.
- R2: Opcode 0x01 reads and opcode 0x02 writes at `pcIn + disp`, where `disp` is sign-extended. On the cycle after the issue `memReq` is 1 and `memAddr` holds the address. `memWe` is 0 for 0x01 and 1 for 0x02. For a write, `memWdata` equals `srcData`.
- R3: Opcode 0x05 reads and opcode 0x06 writes at `baseVal + disp`. `memWe` and `memWdata` behave as in R2.
- R4: Opcode 0x04 asserts `regWe` with `regWdata = pcIn + disp`, truncated to the word width. It never makes a memory request and never faults, even when that sum is out of range.
- R5: Opcode 0x03 asserts `regWe` with `regWdata` equal to the sign-extended `disp`. It makes no request.
- R6: Opcode 0x18 (push) writes `srcData` at `spIn - 1`. It also asserts `spWe` with `spNext = spIn - 1`.
- R7: Opcode 0x19 (pop) reads at `spIn`. It also asserts `spWe` with `spNext = spIn + 1`.
- R8: Operands are two's complement. An effective address is in range only when it lies between 0 and MEM_WORDS-1 inclusive. An out-of-range access issues no request and no stack update, and `fault` is 1 on the next cycle.
- R9: Once set, `fault` stays 1 until reset. While it is set, no issue produces `memReq`, `regWe` or `spWe`.
- R10: A cycle with `issueValid` low produces no strobe on the next cycle. So does any opcode outside the set listed above, such as 0x00, 0x07 or 0x10.
- R11: The strobes of an issue last for exactly one cycle. The cycle after that reflects only the next issue, or is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is issued this cycle |
| opcode | input | 8 | Decoded opcode |
| pcIn | input | WORD_W | Program counter of the instruction |
| disp | input | DISP_W | Signed displacement or immediate |
| baseVal | input | WORD_W | Base register value for indirect forms |
| srcData | input | WORD_W | Register value to store or push |
| spIn | input | WORD_W | Current stack pointer |
| memReq | output | 1 | One-cycle memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Word address of the request |
| memWdata | output | WORD_W | Store data |
| regWe | output | 1 | Register write-back strobe |
| regWdata | output | WORD_W | Register write-back value |
| spWe | output | 1 | Stack pointer update strobe |
| spNext | output | WORD_W | New stack pointer |
| fault | output | 1 | Sticky halt-with-error flag |

## Verification
The hardest cases to reach are the ones where an address sits exactly one word past either end of memory. These include a push with the stack pointer at zero and an indirect access with a negative base. Random operands almost never land there, so random stimulus alone would not find them. The random phase therefore picks each target address inside the memory and derives the displacement from it. Directed cases then place the address at MEM_WORDS-1, at MEM_WORDS and at -1, and check that the fault stays set across later valid issues before a reset clears it.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;
  localparam logic [7:0] OP_LOAD   = 8'h01;
  localparam logic [7:0] OP_STORE  = 8'h02;
  localparam logic [7:0] OP_LDIMM  = 8'h03;
  localparam logic [7:0] OP_LDADDR = 8'h04;
  localparam logic [7:0] OP_LDIND  = 8'h05;
  localparam logic [7:0] OP_STIND  = 8'h06;
  localparam logic [7:0] OP_PUSH   = 8'h18;
  localparam logic [7:0] OP_POP    = 8'h19;

  typedef enum logic [1:0] {SRC_PC, SRC_BASE, SRC_SP} srcSel_e;
  typedef enum logic [1:0] {OFF_DISP, OFF_DEC, OFF_ZERO} offSel_e;

  typedef struct packed {
    srcSel_e srcSel;
    offSel_e offSel;
    logic    doReq;
    logic    doWrite;
    logic    doRegAddr;
    logic    doRegImm;
    logic    doSp;
    logic    spInc;
  } agStrobe_t;
endpackage

// File: rtl/addr_guard_ctrl.sv
module addr_guard_ctrl
  import addr_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issueValid,
  input  logic [7:0] opcode,
  input  logic      inRange,
  output agStrobe_t strobes,
  output logic      faultQ
);
  logic isMem, isWrite, isAddr, isImm, isStack, isInc;
  srcSel_e src;
  offSel_e off;
  logic fire;

  always_comb begin
    isMem = 1'b0; isWrite = 1'b0; isAddr = 1'b0; isImm = 1'b0;
    isStack = 1'b0; isInc = 1'b0; src = SRC_PC; off = OFF_DISP;
    case (opcode)
      OP_LOAD:   isMem = 1'b1;
      OP_STORE:  begin isMem = 1'b1; isWrite = 1'b1; end
      OP_LDADDR: isAddr = 1'b1;
      OP_LDIMM:  isImm = 1'b1;
      OP_LDIND:  begin isMem = 1'b1; src = SRC_BASE; end
      OP_STIND:  begin isMem = 1'b1; isWrite = 1'b1; src = SRC_BASE; end
      OP_PUSH:   begin isMem = 1'b1; isWrite = 1'b1; isStack = 1'b1; src = SRC_SP; off = OFF_DEC; end
      OP_POP:    begin isMem = 1'b1; isStack = 1'b1; isInc = 1'b1; src = SRC_SP; off = OFF_ZERO; end
      default:   ;
    endcase
  end

  assign fire = issueValid && !faultQ;

  always_comb begin
    strobes.srcSel    = src;
    strobes.offSel    = off;
    strobes.doReq     = fire && isMem && inRange;
    strobes.doWrite   = isWrite;
    strobes.doRegAddr = fire && isAddr;
    strobes.doRegImm  = fire && isImm;
    strobes.doSp      = fire && isStack && inRange;
    strobes.spInc     = isInc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) faultQ <= 1'b0;
    else if (fire && isMem && !inRange) faultQ <= 1'b1;
  end

  // R9: fault holds until reset
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    faultQ |=> faultQ);
  // R8: fault only rises after an issue
  a_r8_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(faultQ) |-> $past(issueValid));
endmodule

// File: rtl/addr_guard_dp.sv
module addr_guard_dp
  import addr_guard_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int DISP_W    = 16,
  parameter int MEM_WORDS = 1024,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  agStrobe_t         strobes,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [DISP_W-1:0] disp,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [WORD_W-1:0] srcData,
  input  logic [WORD_W-1:0] spIn,
  output logic              inRange,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              regWe,
  output logic [WORD_W-1:0] regWdata,
  output logic              spWe,
  output logic [WORD_W-1:0] spNext
);
  localparam logic [WORD_W-1:0] MEM_LIMIT = WORD_W'(MEM_WORDS);

  logic [WORD_W-1:0] srcVal;
  logic [WORD_W:0]   offExt;
  logic [WORD_W:0]   eaWide;
  logic [WORD_W-1:0] dispExt;
  logic [WORD_W-1:0] spCalc;

  assign dispExt = WORD_W'($signed(disp));

  always_comb begin
    case (strobes.srcSel)
      SRC_BASE: srcVal = baseVal;
      SRC_SP:   srcVal = spIn;
      default:  srcVal = pcIn;
    endcase
    case (strobes.offSel)
      OFF_DEC:  offExt = '1;
      OFF_ZERO: offExt = '0;
      default:  offExt = {dispExt[WORD_W-1], dispExt};
    endcase
  end

  assign eaWide  = {srcVal[WORD_W-1], srcVal} + offExt;
  assign inRange = !eaWide[WORD_W] && (eaWide[WORD_W-1:0] < MEM_LIMIT);
  assign spCalc  = strobes.spInc ? spIn + 1'b1 : spIn - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      memReq <= 1'b0; memWe <= 1'b0; memAddr <= '0; memWdata <= '0;
      regWe <= 1'b0; regWdata <= '0; spWe <= 1'b0; spNext <= '0;
    end else begin
      memReq   <= strobes.doReq;
      memWe    <= strobes.doReq && strobes.doWrite;
      memAddr  <= strobes.doReq ? eaWide[ADDR_W-1:0] : '0;
      memWdata <= (strobes.doReq && strobes.doWrite) ? srcData : '0;
      regWe    <= strobes.doRegAddr || strobes.doRegImm;
      regWdata <= strobes.doRegImm  ? dispExt :
                  strobes.doRegAddr ? eaWide[WORD_W-1:0] : '0;
      spWe     <= strobes.doSp;
      spNext   <= strobes.doSp ? spCalc : '0;
    end
  end

  // R8: a request is only granted for an in-range address
  a_r8_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doReq |-> inRange);
  // R2: a write strobe never appears without a request
  a_r2_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> memReq);
  // R6: the stack pointer only moves together with an access
  a_r6_sp_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    spWe |-> memReq);
endmodule

// File: rtl/addr_guard_unit.sv
module addr_guard_unit
  import addr_guard_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int DISP_W    = 16,
  parameter int MEM_WORDS = 1024,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [7:0]        opcode,
  input  logic [WORD_W-1:0] pcIn,
  input  logic [DISP_W-1:0] disp,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [WORD_W-1:0] srcData,
  input  logic [WORD_W-1:0] spIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              regWe,
  output logic [WORD_W-1:0] regWdata,
  output logic              spWe,
  output logic [WORD_W-1:0] spNext,
  output logic              fault
);
  agStrobe_t strobes;
  logic inRange;

  addr_guard_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .opcode(opcode),
    .inRange(inRange), .strobes(strobes), .faultQ(fault)
  );

  addr_guard_dp #(.WORD_W(WORD_W), .DISP_W(DISP_W), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .pcIn(pcIn), .disp(disp),
    .baseVal(baseVal), .srcData(srcData), .spIn(spIn), .inRange(inRange),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .regWe(regWe), .regWdata(regWdata), .spWe(spWe), .spNext(spNext)
  );

  // R9: a halted processor drives no strobe
  a_r9_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> !(memReq || regWe || spWe));
endmodule

// File: tb/addr_guard_unit_bench.sv
module addr_guard_unit_bench;
  localparam int WORD_W = 32;
  localparam int DISP_W = 16;
  localparam int MEM_WORDS = 1024;
  localparam int ADDR_W = $clog2(MEM_WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issueValid = 1'b0;
  logic [7:0] opcode = '0;
  logic [WORD_W-1:0] pcIn = '0, baseVal = '0, srcData = '0, spIn = '0;
  logic [DISP_W-1:0] disp = '0;
  logic memReq, memWe, regWe, spWe, fault;
  logic [ADDR_W-1:0] memAddr;
  logic [WORD_W-1:0] memWdata, regWdata, spNext;

  int checks = 0;
  int fails = 0;
  logic mFault = 1'b0;

  typedef struct packed {
    logic              req;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic              rwe;
    logic [WORD_W-1:0] rdata;
    logic              swe;
    logic [WORD_W-1:0] snext;
    logic              flt;
  } obs_t;

  always #5 clk = ~clk;

  addr_guard_unit u_addr_guard_unit (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .opcode(opcode),
    .pcIn(pcIn), .disp(disp), .baseVal(baseVal), .srcData(srcData), .spIn(spIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .regWe(regWe), .regWdata(regWdata), .spWe(spWe), .spNext(spNext), .fault(fault)
  );

  function automatic obs_t predict(logic v, logic [7:0] op, logic [WORD_W-1:0] pc,
      logic [DISP_W-1:0] d, logic [WORD_W-1:0] b, logic [WORD_W-1:0] s,
      logic [WORD_W-1:0] sp, logic fIn);
    obs_t e = '0;
    longint dv = longint'($signed(d));
    longint ea = 0;
    logic mem = 1'b0, wr = 1'b0, stk = 1'b0;
    case (op)
      8'h01: begin mem = 1; ea = longint'($signed(pc)) + dv; end
      8'h02: begin mem = 1; wr = 1; ea = longint'($signed(pc)) + dv; end
      8'h05: begin mem = 1; ea = longint'($signed(b)) + dv; end
      8'h06: begin mem = 1; wr = 1; ea = longint'($signed(b)) + dv; end
      8'h18: begin mem = 1; wr = 1; stk = 1; ea = longint'($signed(sp)) - 1; end
      8'h19: begin mem = 1; stk = 1; ea = longint'($signed(sp)); end
      default: ;
    endcase
    e.flt = fIn;
    if (!v || fIn) return e;
    if (op == 8'h04) begin e.rwe = 1; e.rdata = WORD_W'(longint'($signed(pc)) + dv); end
    if (op == 8'h03) begin e.rwe = 1; e.rdata = WORD_W'(dv); end
    if (mem) begin
      if (ea < 0 || ea >= MEM_WORDS) e.flt = 1;
      else begin
        e.req = 1; e.we = wr; e.addr = ADDR_W'(ea);
        if (wr) e.wdata = s;
        if (stk) begin
          e.swe = 1;
          e.snext = (op == 8'h18) ? sp - 1 : sp + 1;
        end
      end
    end
    return e;
  endfunction

  function automatic obs_t observed();
    return '{memReq, memWe, memAddr, memWdata, regWe, regWdata, spWe, spNext, fault};
  endfunction

  task automatic check(string tag, obs_t exp);
    obs_t act = observed();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, outputs registered on the next posedge, sample at following negedge
  task automatic issue(string tag, logic v, logic [7:0] op, logic [WORD_W-1:0] pc,
      logic [DISP_W-1:0] d, logic [WORD_W-1:0] b, logic [WORD_W-1:0] s,
      logic [WORD_W-1:0] sp);
    obs_t e;
    issueValid = v; opcode = op; pcIn = pc; disp = d; baseVal = b; srcData = s; spIn = sp;
    e = predict(v, op, pc, d, b, s, sp, mFault);
    @(negedge clk);
    check(tag, e);
    mFault = e.flt;
  endtask

  task automatic idle(string tag);
    issue(tag, 1'b0, 8'h01, 32'd5, 16'd0, 0, 0, 0);
  endtask

  task automatic doReset();
    rst_n = 1'b0; issueValid = 1'b0;
    @(negedge clk);
    check("R1 reset held", '0);
    @(negedge clk);
    rst_n = 1'b1; mFault = 1'b0;
    @(negedge clk);
    check("R1 after reset", '0);
  endtask

  initial begin
    int limit = 100000;
    repeat (limit) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ops [10] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h18, 8'h19, 8'h00, 8'h07};
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // random, addresses kept in range
    for (int i = 0; i < 600; i++) begin
      logic [7:0] op = ops[$urandom_range(0, 9)];
      logic [WORD_W-1:0] pc = $urandom_range(0, 4000);
      logic [WORD_W-1:0] tgt = $urandom_range(0, MEM_WORDS - 1);
      logic [WORD_W-1:0] b = $urandom_range(0, 4000);
      logic [WORD_W-1:0] s = $urandom;
      logic [WORD_W-1:0] sp = (op == 8'h18) ? $urandom_range(1, MEM_WORDS) : $urandom_range(0, MEM_WORDS - 1);
      logic [DISP_W-1:0] d;
      logic v = ($urandom_range(0, 7) != 0);
      if (op == 8'h05 || op == 8'h06) d = DISP_W'(tgt - b);
      else if (op == 8'h03) d = DISP_W'($urandom);
      else d = DISP_W'(tgt - pc);
      issue("R2 R3 R5 R6 R7 R10 R11 random", v, op, pc, d, b, s, sp);
    end
    idle("R11 idle after burst");

    // boundaries
    issue("R2 load at top word", 1, 8'h01, 32'd1000, 16'd23, 0, 0, 0);
    issue("R4 ldaddr out of range no fault", 1, 8'h04, 32'd1000, 16'd5000, 0, 0, 0);
    issue("R5 ldimm negative", 1, 8'h03, 0, 16'hFFF0, 0, 0, 0);
    issue("R7 pop at top word", 1, 8'h19, 0, 0, 0, 0, 32'd1023);
    issue("R6 push at sp=1", 1, 8'h18, 0, 0, 0, 32'hA5A5, 32'd1);
    issue("R10 unknown opcode", 1, 8'h10, 32'd3, 16'd1, 0, 0, 0);
    issue("R10 valid low", 0, 8'h02, 32'd3, 16'd1, 0, 32'h77, 0);
    issue("R8 store one past end", 1, 8'h02, 32'd1000, 16'd24, 0, 32'h55, 0);
    issue("R9 load after fault", 1, 8'h01, 32'd10, 16'd1, 0, 0, 0);
    issue("R9 ldimm after fault", 1, 8'h03, 0, 16'd9, 0, 0, 0);
    idle("R9 still faulted");
    doReset();
    issue("R8 negative base", 1, 8'h05, 0, 16'd3, 32'hFFFF_FFFB, 0, 0);
    issue("R9 push after fault", 1, 8'h18, 0, 0, 0, 1, 32'd10);
    doReset();
    issue("R8 push at sp=0", 1, 8'h18, 0, 0, 0, 32'h1, 32'd0);
    doReset();
    issue("R8 pop past end", 1, 8'h19, 0, 0, 0, 0, 32'd1024);
    doReset();
    issue("R8 pc-relative negative", 1, 8'h01, 32'd2, 16'hFFFD, 0, 0, 0);
    doReset();
    issue("R3 indirect write at zero", 1, 8'h06, 0, 16'hFFFB, 32'd5, 32'hDEAD, 0);
    idle("R11 one cycle strobe");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule